// File: doc/BRIEF.md
# Core Wait and Event Controller

This block sits beside one processor core. It handles the two wait hints, wait-for-event and wait-for-interrupt. It keeps one hidden event flag for that core. The decoder hands it one-cycle hint pulses.

When a wait hint arrives, the block makes one of three choices:
- complete the hint at once;
- raise a request to trap to the hypervisor;
- put the core to sleep.

While the core sleeps, the block watches the wake sources that apply to the wait kind that was issued. It releases the core with a one-cycle wake pulse. A broadcast send-event also leaves the block as a pulse, wired to the event inputs of the other cores. The block does not gate the clock or the power itself.

The event flag cannot be read from outside. Its value shows only through how the next event-wait behaves.

Top module: `evw_wait_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `sleeping`, `wake_pulse`, `trap_req` and `event_out` are low, and the event flag is 0. This means the first event-wait after reset goes to sleep.
- R2: An event-wait that sees the flag set clears the flag and stays awake. `wake_pulse` goes high for one cycle in the cycle after the hint, and a following event-wait then sleeps.
- R3: An event-wait that sees the flag clear and is not trapped makes `sleeping` rise in the cycle after the hint.
- R4: The flag is set by any of these: a broadcast or local send-event hint, any `peer_event` bit, `impl_event`, `timer_stream`, `dbg_entry` or `exc_return`. When a set and a clear fall in the same cycle, the flag ends up set.
- R5: A broadcast send-event hint taken while awake drives `event_out` high for exactly the next cycle. The local send-event never drives `event_out`.
- R6: Event-wait sleep ends on any of these:
  - `irq` with `irq_mask` low;
  - `fiq` with `fiq_mask` low;
  - `async_abort` with `abort_mask` low;
  - `dbg_req` with `dbg_en` high;
  - any `peer_event`, `impl_event` or `timer_stream` input;
  - a set flag.

  Masked sources leave the core asleep.
- R7: Interrupt-wait sleep ends on any of these:
  - `irq` or `fiq`, whatever the mask;
  - an unmasked `async_abort`;
  - `dbg_req`, whatever `dbg_en` is.

  Event inputs do not end it, but they still set the flag, so a later event-wait completes at once.
- R8: The trap rule applies when `non_secure` is high and `hyp_mode` is low. Under it, an event-wait that would sleep with `wfe_trap_en` high raises `trap_req` for one cycle instead. An interrupt-wait with `wfi_trap_en` high does the same. In both cases the core stays awake. An event-wait that finds the flag set completes normally and is not trapped.
- R9: On a wake from sleep, `sleeping` falls and `wake_pulse` is high in the same cycle, one cycle after the wake condition. A wake from event-wait leaves the flag cleared unless a new set arrives in that cycle.
- R10: All hints are ignored while asleep. An event-wait and an interrupt-wait issued in the same cycle act as an event-wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfe_hint | input | 1 | Event-wait hint pulse |
| wfi_hint | input | 1 | Interrupt-wait hint pulse |
| sev_hint | input | 1 | Broadcast send-event hint pulse |
| sevl_hint | input | 1 | Local send-event hint pulse |
| irq | input | 1 | Normal interrupt line |
| fiq | input | 1 | Fast interrupt line |
| async_abort | input | 1 | Asynchronous abort line |
| irq_mask | input | 1 | Mask for `irq` |
| fiq_mask | input | 1 | Mask for `fiq` |
| abort_mask | input | 1 | Mask for `async_abort` |
| dbg_req | input | 1 | Debug entry request |
| dbg_en | input | 1 | Invasive debug enabled |
| dbg_entry | input | 1 | Core entered debug state (sets flag) |
| exc_return | input | 1 | Exception return (sets flag) |
| wfe_trap_en | input | 1 | Hypervisor trap enable for event-wait |
| wfi_trap_en | input | 1 | Hypervisor trap enable for interrupt-wait |
| non_secure | input | 1 | Core is in non-secure state |
| hyp_mode | input | 1 | Core is in hypervisor mode |
| peer_event | input | N_PEER | Event lines from other cores |
| impl_event | input | 1 | Implementation-specific event |
| timer_stream | input | 1 | Periodic timer event stream |
| sleeping | output | 1 | Core is held in a wait |
| wake_pulse | output | 1 | One-cycle pulse when a wait completes |
| trap_req | output | 1 | One-cycle hypervisor trap request |
| event_out | output | 1 | Broadcast event to other cores |

## Verification
The hardest state to reach from the ports is a flag that is set while the core is in interrupt-wait sleep. The flag cannot be seen at the ports, and the wake that follows must not be caused by the event. The stimulus does it in four steps:
1. Put the core into interrupt-wait.
2. Pulse a peer event, and observe that the core stays asleep.
3. Wake the core with a masked `irq`.
4. Issue an event-wait, and observe that it completes at once.

A second hard case is an event-wait entered in the same cycle as a set source, or a flag set by debug entry during sleep. In both, the wake comes one cycle later, from the flag itself. The cycle-level reference model predicts exactly when that happens.

// File: rtl/evw_pkg.sv
package evw_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_SLEEP_WFE = 2'd1,
    ST_SLEEP_WFI = 2'd2
  } evw_state_e;
endpackage

// File: rtl/evw_event_flag.sv
module evw_event_flag #(
  parameter int N_SET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SET-1:0] set_req,
  input  logic             clr_req,
  output logic             ev_q
);
  logic ev_d;
  logic ev_en;

  // set beats clear so an event never vanishes
  always_comb begin
    ev_en = (|set_req) | clr_req;
    ev_d  = |set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= 1'b0;
    else if (ev_en) ev_q <= ev_d;
  end

  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_req) |=> ev_q);
  a_r2_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(|set_req)) |=> !ev_q);
endmodule

// File: rtl/evw_wake_qual.sv
module evw_wake_qual #(
  parameter int N_PEER = 3
) (
  input  logic              irq,
  input  logic              fiq,
  input  logic              async_abort,
  input  logic              irq_mask,
  input  logic              fiq_mask,
  input  logic              abort_mask,
  input  logic              dbg_req,
  input  logic              dbg_en,
  input  logic [N_PEER-1:0] peer_event,
  input  logic              impl_event,
  input  logic              timer_stream,
  output logic              ext_event,
  output logic              wfe_wake_src,
  output logic              wfi_wake
);
  logic [N_PEER-1:0] peer_seen;
  logic              abort_live;

  genvar gi;
  generate
    for (gi = 0; gi < N_PEER; gi++) begin : g_peer
      assign peer_seen[gi] = peer_event[gi];
    end
  endgenerate

  always_comb begin
    abort_live   = async_abort & ~abort_mask;
    ext_event    = (|peer_seen) | impl_event | timer_stream;
    wfe_wake_src = ext_event
                 | (irq & ~irq_mask)
                 | (fiq & ~fiq_mask)
                 | abort_live
                 | (dbg_req & dbg_en);
    wfi_wake     = irq | fiq | abort_live | dbg_req;
  end
endmodule

// File: rtl/evw_fsm.sv
module evw_fsm
  import evw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfe_hint,
  input  logic       wfi_hint,
  input  logic       sev_hint,
  input  logic       sevl_hint,
  input  logic       ev_q,
  input  logic       trap_wfe_ok,
  input  logic       trap_wfi_ok,
  input  logic       wfe_wake_src,
  input  logic       wfi_wake,
  output evw_state_e state_q,
  output logic       local_set,
  output logic       flag_clr,
  output logic       resume_q,
  output logic       trap_q,
  output logic       evout_q
);
  evw_state_e state_d;
  logic run, take_wfe, take_wfi;
  logic wfe_now, wfe_trap, wfi_trap, wake_e, wake_i;
  logic resume_d, trap_d, evout_d;

  always_comb begin
    run      = (state_q == ST_RUN);
    take_wfe = run & wfe_hint;
    take_wfi = run & wfi_hint & ~wfe_hint;
    wfe_now  = take_wfe & ev_q;
    wfe_trap = take_wfe & ~ev_q & trap_wfe_ok;
    wfi_trap = take_wfi & trap_wfi_ok;
    wake_e   = (state_q == ST_SLEEP_WFE) & (wfe_wake_src | ev_q);
    wake_i   = (state_q == ST_SLEEP_WFI) & wfi_wake;
    state_d  = state_q;
    if (take_wfe && !ev_q && !trap_wfe_ok) state_d = ST_SLEEP_WFE;
    else if (take_wfi && !trap_wfi_ok)     state_d = ST_SLEEP_WFI;
    else if (wake_e || wake_i)             state_d = ST_RUN;
    local_set = run & (sev_hint | sevl_hint);
    flag_clr  = wfe_now | wake_e;
    resume_d  = wfe_now | wake_e | wake_i;
    trap_d    = wfe_trap | wfi_trap;
    evout_d   = run & sev_hint;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      resume_q <= 1'b0;
      trap_q   <= 1'b0;
      evout_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      trap_q   <= trap_d;
      evout_q  <= evout_d;
    end
  end

  a_r2_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && wfe_hint && ev_q) |=> (state_q == ST_RUN && resume_q));
  a_r6_wfe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP_WFE && !wfe_wake_src && !ev_q) |=> (state_q == ST_SLEEP_WFE));
  a_r7_wfi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP_WFI && !wfi_wake) |=> (state_q == ST_SLEEP_WFI));
  a_r10_no_evout_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |=> !evout_q);
endmodule

// File: rtl/evw_wait_ctrl.sv
module evw_wait_ctrl
  import evw_pkg::*;
#(
  parameter int N_PEER = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfe_hint,
  input  logic              wfi_hint,
  input  logic              sev_hint,
  input  logic              sevl_hint,
  input  logic              irq,
  input  logic              fiq,
  input  logic              async_abort,
  input  logic              irq_mask,
  input  logic              fiq_mask,
  input  logic              abort_mask,
  input  logic              dbg_req,
  input  logic              dbg_en,
  input  logic              dbg_entry,
  input  logic              exc_return,
  input  logic              wfe_trap_en,
  input  logic              wfi_trap_en,
  input  logic              non_secure,
  input  logic              hyp_mode,
  input  logic [N_PEER-1:0] peer_event,
  input  logic              impl_event,
  input  logic              timer_stream,
  output logic              sleeping,
  output logic              wake_pulse,
  output logic              trap_req,
  output logic              event_out
);
  localparam int N_SET = 4;

  evw_state_e       state_q;
  logic             ev_q, local_set, flag_clr;
  logic             ext_event, wfe_wake_src, wfi_wake;
  logic             trap_zone, trap_wfe_ok, trap_wfi_ok, ext_set;
  logic [N_SET-1:0] set_vec;

  always_comb begin
    trap_zone   = non_secure & ~hyp_mode;
    trap_wfe_ok = trap_zone & wfe_trap_en;
    trap_wfi_ok = trap_zone & wfi_trap_en;
    // in event-wait sleep an incoming event is spent as the wake itself
    ext_set     = ext_event & (state_q != ST_SLEEP_WFE);
    set_vec     = {local_set, ext_set, dbg_entry, exc_return};
    sleeping    = (state_q != ST_RUN);
  end

  evw_wake_qual #(.N_PEER(N_PEER)) u_qual (
    .irq(irq), .fiq(fiq), .async_abort(async_abort),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask), .abort_mask(abort_mask),
    .dbg_req(dbg_req), .dbg_en(dbg_en), .peer_event(peer_event),
    .impl_event(impl_event), .timer_stream(timer_stream),
    .ext_event(ext_event), .wfe_wake_src(wfe_wake_src), .wfi_wake(wfi_wake)
  );

  evw_event_flag #(.N_SET(N_SET)) u_flag (
    .clk(clk), .rst_n(rst_n), .set_req(set_vec), .clr_req(flag_clr), .ev_q(ev_q)
  );

  evw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .wfe_hint(wfe_hint), .wfi_hint(wfi_hint),
    .sev_hint(sev_hint), .sevl_hint(sevl_hint),
    .ev_q(ev_q), .trap_wfe_ok(trap_wfe_ok), .trap_wfi_ok(trap_wfi_ok),
    .wfe_wake_src(wfe_wake_src), .wfi_wake(wfi_wake),
    .state_q(state_q), .local_set(local_set), .flag_clr(flag_clr),
    .resume_q(wake_pulse), .trap_q(trap_req), .evout_q(event_out)
  );

  a_r9_fall_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleeping) |-> wake_pulse);
  a_r9_awake_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !sleeping);
  a_r8_trap_awake: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (!sleeping && !wake_pulse));
  a_r5_evout_source: assert property (@(posedge clk) disable iff (!rst_n)
    event_out |-> $past(sev_hint && !sleeping));
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_pulse, trap_req}));
endmodule

// File: tb/evw_wait_ctrl_test.sv
module evw_wait_ctrl_test;
  localparam int NP = 3;
  logic clk = 1'b0;
  logic rst_n;
  logic wfe_hint, wfi_hint, sev_hint, sevl_hint;
  logic irq, fiq, async_abort, irq_mask, fiq_mask, abort_mask;
  logic dbg_req, dbg_en, dbg_entry, exc_return;
  logic wfe_trap_en, wfi_trap_en, non_secure, hyp_mode;
  logic [NP-1:0] peer_event;
  logic impl_event, timer_stream;
  logic sleeping, wake_pulse, trap_req, event_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference: 0 awake, 1 event-wait sleep, 2 interrupt-wait sleep
  int m_st;
  bit m_ev, m_res, m_trp, m_eo;
  int n_st;
  bit n_ev, n_res, n_trp, n_eo, evx, trapzone;

  always #2 clk = ~clk;

  evw_wait_ctrl #(.N_PEER(NP)) uut (
    .clk(clk), .rst_n(rst_n), .wfe_hint(wfe_hint), .wfi_hint(wfi_hint),
    .sev_hint(sev_hint), .sevl_hint(sevl_hint), .irq(irq), .fiq(fiq),
    .async_abort(async_abort), .irq_mask(irq_mask), .fiq_mask(fiq_mask),
    .abort_mask(abort_mask), .dbg_req(dbg_req), .dbg_en(dbg_en),
    .dbg_entry(dbg_entry), .exc_return(exc_return), .wfe_trap_en(wfe_trap_en),
    .wfi_trap_en(wfi_trap_en), .non_secure(non_secure), .hyp_mode(hyp_mode),
    .peer_event(peer_event), .impl_event(impl_event), .timer_stream(timer_stream),
    .sleeping(sleeping), .wake_pulse(wake_pulse), .trap_req(trap_req),
    .event_out(event_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ev = 0; m_res = 0; m_trp = 0; m_eo = 0;
    end else begin
      evx = (peer_event != 0) || impl_event || timer_stream;
      trapzone = non_secure && !hyp_mode;
      n_st = m_st; n_ev = m_ev; n_res = 0; n_trp = 0; n_eo = 0;
      if (m_st == 0) begin
        if (wfe_hint) begin
          if (m_ev) begin n_res = 1; n_ev = 0; end
          else if (trapzone && wfe_trap_en) n_trp = 1;
          else n_st = 1;
        end else if (wfi_hint) begin
          if (trapzone && wfi_trap_en) n_trp = 1;
          else n_st = 2;
        end
        if (sev_hint) begin n_ev = 1; n_eo = 1; end
        if (sevl_hint || evx) n_ev = 1;
      end else if (m_st == 1) begin
        if (m_ev || evx || (irq && !irq_mask) || (fiq && !fiq_mask) ||
            (async_abort && !abort_mask) || (dbg_req && dbg_en)) begin
          n_st = 0; n_res = 1; n_ev = 0;
        end
      end else begin
        if (irq || fiq || (async_abort && !abort_mask) || dbg_req) begin
          n_st = 0; n_res = 1;
        end
        if (evx) n_ev = 1;
      end
      if (dbg_entry || exc_return) n_ev = 1;
      m_st = n_st; m_ev = n_ev; m_res = n_res; m_trp = n_trp; m_eo = n_eo;
    end
  end

  task automatic compare();
    checks++;
    if (sleeping !== (m_st != 0) || wake_pulse !== m_res ||
        trap_req !== m_trp || event_out !== m_eo) begin
      fails++;
      $display("FAIL %s: sleep/wake/trap/evout actual=%b%b%b%b expected=%b%b%b%b",
               tag, sleeping, wake_pulse, trap_req, event_out,
               (m_st != 0), m_res, m_trp, m_eo);
    end
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic clear_pulses();
    wfe_hint = 0; wfi_hint = 0; sev_hint = 0; sevl_hint = 0;
    irq = 0; fiq = 0; async_abort = 0; dbg_req = 0; dbg_entry = 0;
    exc_return = 0; peer_event = '0; impl_event = 0; timer_stream = 0;
  endtask

  task automatic pulse_cyc();
    cyc(1);
    clear_pulses();
  endtask

  initial begin
    int limit = 20000;
    while (cycles < limit) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cycles, limit);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_pulses();
    irq_mask = 0; fiq_mask = 0; abort_mask = 0; dbg_en = 0;
    wfe_trap_en = 0; wfi_trap_en = 0; non_secure = 0; hyp_mode = 0;
    tag = "R1";
    cyc(3);
    @(negedge clk); rst_n = 1;
    cyc(2);
    // R1: cleared flag means first event-wait sleeps
    wfe_hint = 1; pulse_cyc(); cyc(2);
    tag = "R6"; irq = 1; pulse_cyc(); cyc(1);

    // R2/R4: local send-event sets flag, event-wait returns at once
    tag = "R4"; sevl_hint = 1; pulse_cyc();
    tag = "R2"; wfe_hint = 1; pulse_cyc(); cyc(1);
    tag = "R3"; wfe_hint = 1; pulse_cyc(); cyc(2);
    tag = "R6"; fiq = 1; pulse_cyc(); cyc(1);

    // R5: broadcast vs local
    tag = "R5"; sev_hint = 1; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc();
    sevl_hint = 1; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc(); cyc(1);

    // R6: masked sources hold, each unmasked source wakes
    tag = "R6"; irq_mask = 1; fiq_mask = 1; abort_mask = 1;
    wfe_hint = 1; pulse_cyc();
    irq = 1; fiq = 1; async_abort = 1; dbg_req = 1; pulse_cyc(); cyc(1);
    peer_event = 3'b010; pulse_cyc(); cyc(1);
    tag = "R9"; wfe_hint = 1; pulse_cyc(); cyc(2);
    tag = "R6"; timer_stream = 1; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc(); impl_event = 1; pulse_cyc(); cyc(1);
    abort_mask = 0; wfe_hint = 1; pulse_cyc(); async_abort = 1; pulse_cyc(); cyc(1);
    dbg_en = 1; wfe_hint = 1; pulse_cyc(); dbg_req = 1; pulse_cyc(); cyc(1);
    dbg_en = 0; abort_mask = 1;

    // R7: interrupt-wait ignores events but they set the flag
    tag = "R7"; wfi_hint = 1; pulse_cyc();
    peer_event = 3'b100; pulse_cyc(); timer_stream = 1; pulse_cyc(); cyc(2);
    async_abort = 1; pulse_cyc(); cyc(1);
    irq = 1; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc(); cyc(1);
    wfi_hint = 1; pulse_cyc(); dbg_req = 1; pulse_cyc(); cyc(1);
    wfi_hint = 1; pulse_cyc(); fiq = 1; pulse_cyc();
    abort_mask = 0; wfi_hint = 1; pulse_cyc(); async_abort = 1; pulse_cyc(); cyc(1);
    irq_mask = 0; fiq_mask = 0;

    // R8: trap rules
    tag = "R8"; non_secure = 1; wfe_trap_en = 1; wfi_trap_en = 1;
    wfe_hint = 1; pulse_cyc(); cyc(1);
    wfi_hint = 1; pulse_cyc(); cyc(1);
    sevl_hint = 1; pulse_cyc(); wfe_hint = 1; pulse_cyc(); cyc(1);
    hyp_mode = 1; wfe_hint = 1; pulse_cyc(); cyc(1); irq = 1; pulse_cyc();
    hyp_mode = 0; non_secure = 0; wfi_hint = 1; pulse_cyc(); fiq = 1; pulse_cyc();
    wfe_trap_en = 0; wfi_trap_en = 0;

    // R10: hints ignored while asleep, event-wait wins a tie
    tag = "R10"; wfe_hint = 1; wfi_hint = 1; pulse_cyc();
    sev_hint = 1; pulse_cyc(); wfi_hint = 1; sevl_hint = 1; pulse_cyc(); cyc(2);
    peer_event = 3'b001; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc(); cyc(1); irq = 1; pulse_cyc();

    // R4: set wins over clear, sets during sleep, set in entry cycle
    tag = "R4"; sevl_hint = 1; pulse_cyc();
    wfe_hint = 1; exc_return = 1; pulse_cyc();
    wfe_hint = 1; pulse_cyc(); cyc(1);
    wfe_hint = 1; pulse_cyc(); cyc(1);
    dbg_entry = 1; pulse_cyc(); cyc(2);
    wfe_hint = 1; sev_hint = 1; pulse_cyc(); cyc(3);
    wfe_hint = 1; pulse_cyc(); fiq = 1; pulse_cyc(); cyc(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule